// File: doc/BRIEF.md
# Lockable One-Time-Programmable Security Register

This block holds a 128-bit security value organised as two 64-bit halves. The first half carries a factory identifier fixed by a parameter. It is visible only for reading. The second half comes out of reset erased to all ones. The user may program it until a lock is applied. Once set, the lock holds until the next reset, which stands in for a nonvolatile fuse. All storage is kept in flip-flops.

A command layer in front of the block decodes the multi-cycle unlock sequences. It hands over one-cycle requests, each with an opcode, a byte address and a data byte. The block keeps a mode of its own. Stored bytes and a lock-status byte can be read only after an identification-mode entry request. While that mode is active, every request other than a read or an exit is refused.

Top module: `otp_secreg`

## Requirements
- R1: After reset, `id_active`, `rd_valid` and `cmd_reject` are low, every user byte reads 0xFF and the lock is clear.
- R2: In identification mode, a read (op 5) at address A_BASE+i returns bits 8i+7..8i of the factory parameter. With defaults, A_BASE+i is 0x00..0x07.
- R3: A program request (op 1) whose address lies outside the user window is refused, and the factory bytes never change. Addresses in the factory window count as outside the user window.
- R4: A program request (op 1) in array mode with the lock clear, at address B_BASE+i (default 0x08..0x0F), is accepted. It leaves user byte i equal to its old value ANDed with the data byte.
- R5: A lock request (op 2) in array mode is accepted. It sets the lock only when data bit 1 is 0, and the other data bits have no influence. With data bit 1 at 1, the lock stays as it was.
- R6: While locked, a program request to the user window is refused and leaves every user byte unchanged.
- R7: A read at address 0x80 returns a status byte. Bit 1 of that byte is 1 while the user half is unlocked and 0 once it is locked, and all other bits are 1.
- R8: A read (op 5) is accepted only in identification mode. In array mode it is refused, and `rd_valid` stays low.
- R9: Entry (op 3) in array mode raises `id_active`. While that mode is active, program, lock and entry requests are refused and have no effect. Exit (op 4) is accepted in either mode and clears `id_active`.
- R10: In the cycle after the edge that takes a request, an accepted read raises `rd_valid` for one cycle and a refused request raises `cmd_reject` for one cycle, never both at once. A read at an unmapped address returns 0xFF.
- R11: No sequence of requests clears the lock once it is set; only reset clears it.
- R12: Opcodes 0, 6 and 7 are refused and change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | A decoded request is present this cycle |
| cmd_op | input | 3 | Request opcode (1 program, 2 lock, 3 enter, 4 exit, 5 read) |
| cmd_addr | input | ADDR_W | Byte address of the request |
| cmd_data | input | WORD_W | Data byte of the request |
| id_active | output | 1 | Identification mode is active |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds the answer to a read |
| rd_data | output | WORD_W | Read result |
| cmd_reject | output | 1 | One-cycle pulse: the previous request was refused |

## Verification
The bench sweeps every byte address in identification mode, both before and after lock, and compares each result against a model built from the requirements. A wrong decode window or a swapped byte order would appear as a mismatch at an exact address. Each user byte is programmed several times with patterns that clear different bits. A store that overwrote instead of ANDing would bring cleared bits back to one. Lock requests are sent with data bit 1 high and with all other bits flipped, and the status byte and the program refusals are then checked. A qualifier taken from the wrong bit, or a lock cleared by a later request or by a mode change, would show up as a status byte of 0xFF or as a program that is accepted. Every refused opcode is also sent in each mode, and the stored bytes are checked afterwards.

// File: rtl/otp_secreg_pkg.sv
package otp_secreg_pkg;

   typedef enum logic [2:0] {
      OP_NONE     = 3'd0,
      OP_PROG     = 3'd1,
      OP_LOCK     = 3'd2,
      OP_ID_ENTER = 3'd3,
      OP_ID_EXIT  = 3'd4,
      OP_READ     = 3'd5
   } otp_op_e;

   typedef enum logic {
      MODE_ARRAY = 1'b0,
      MODE_IDENT = 1'b1
   } otp_mode_e;

endpackage

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
   import otp_secreg_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int NWORDS = 8,
   parameter int B_BASE = 8,
   localparam int IDX_W = $clog2(NWORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic              lock_qual,
   input  logic              locked,
   output logic              id_active,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic              lock_set,
   output logic              rd_en,
   output logic              reject
);

   otp_op_e   op;
   otp_mode_e mode_q, mode_d;
   logic      in_user;
   logic      accept;
   logic      reject_q;

   assign op      = otp_op_e'(cmd_op);
   assign in_user = (int'(cmd_addr) >= B_BASE) && (int'(cmd_addr) < B_BASE + NWORDS);
   assign wr_idx  = IDX_W'(int'(cmd_addr) - B_BASE);

   always_comb begin
      accept   = 1'b0;
      wr_en    = 1'b0;
      lock_set = 1'b0;
      rd_en    = 1'b0;
      mode_d   = mode_q;
      if (cmd_valid) begin
         case (op)
            OP_PROG: begin
               if (mode_q == MODE_ARRAY && in_user && !locked) begin
                  accept = 1'b1;
                  wr_en  = 1'b1;
               end
            end
            OP_LOCK: begin
               if (mode_q == MODE_ARRAY) begin
                  accept   = 1'b1;
                  lock_set = !lock_qual;
               end
            end
            OP_ID_ENTER: begin
               if (mode_q == MODE_ARRAY) begin
                  accept = 1'b1;
                  mode_d = MODE_IDENT;
               end
            end
            OP_ID_EXIT: begin
               accept = 1'b1;
               mode_d = MODE_ARRAY;
            end
            OP_READ: begin
               if (mode_q == MODE_IDENT) begin
                  accept = 1'b1;
                  rd_en  = 1'b1;
               end
            end
            default: accept = 1'b0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q   <= MODE_ARRAY;
         reject_q <= 1'b0;
      end else begin
         mode_q   <= mode_d;
         reject_q <= cmd_valid && !accept;
      end
   end

   assign id_active = (mode_q == MODE_IDENT);
   assign reject    = reject_q;

endmodule

// File: rtl/otp_half_store.sv
module otp_half_store #(
   parameter int WORD_W   = 8,
   parameter int NWORDS   = 8,
   parameter bit WRITABLE = 1'b1,
   parameter logic [NWORDS*WORD_W-1:0] INIT = '1,
   localparam int IDX_W  = $clog2(NWORDS),
   localparam int BITS   = NWORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_data,
   output logic [BITS-1:0]   words
);

   generate
      if (WRITABLE) begin : g_rw
         for (genvar i = 0; i < NWORDS; i++) begin : g_word
            logic [WORD_W-1:0] cell_q;
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cell_q <= INIT[i*WORD_W +: WORD_W];
               end else if (wr_en && wr_idx == IDX_W'(i)) begin
                  cell_q <= cell_q & wr_data;
               end
            end
            assign words[i*WORD_W +: WORD_W] = cell_q;
         end
      end else begin : g_ro
         logic unused_ro;
         assign unused_ro = ^{clk, rst_n, wr_en, wr_idx, wr_data};
         for (genvar i = 0; i < NWORDS; i++) begin : g_word
            assign words[i*WORD_W +: WORD_W] = INIT[i*WORD_W +: WORD_W];
         end
      end
   endgenerate

endmodule

// File: rtl/otp_rd_mux.sv
module otp_rd_mux #(
   parameter int ADDR_W      = 8,
   parameter int WORD_W      = 8,
   parameter int NWORDS      = 8,
   parameter int A_BASE      = 0,
   parameter int B_BASE      = 8,
   parameter int STATUS_ADDR = 'h80,
   parameter int LOCK_BIT    = 1,
   parameter bit RD_PIPE     = 1'b1,
   localparam int BITS       = NWORDS * WORD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [BITS-1:0]   a_words,
   input  logic [BITS-1:0]   b_words,
   input  logic              locked,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data
);

   logic [WORD_W-1:0] sel;
   int                a_off, b_off;

   assign a_off = int'(rd_addr) - A_BASE;
   assign b_off = int'(rd_addr) - B_BASE;

   always_comb begin
      sel = '1;
      if (a_off >= 0 && a_off < NWORDS) begin
         sel = a_words[a_off*WORD_W +: WORD_W];
      end else if (b_off >= 0 && b_off < NWORDS) begin
         sel = b_words[b_off*WORD_W +: WORD_W];
      end else if (int'(rd_addr) == STATUS_ADDR) begin
         sel           = '1;
         sel[LOCK_BIT] = !locked;
      end
   end

   generate
      if (RD_PIPE) begin : g_pipe
         logic              vld_q;
         logic [WORD_W-1:0] dat_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               dat_q <= '1;
            end else begin
               vld_q <= rd_en;
               if (rd_en) dat_q <= sel;
            end
         end
         assign rd_valid = vld_q;
         assign rd_data  = dat_q;
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = ^{clk, rst_n};
         assign rd_valid   = rd_en;
         assign rd_data    = sel;
      end
   endgenerate

endmodule

// File: rtl/otp_secreg.sv
module otp_secreg
   import otp_secreg_pkg::*;
#(
   parameter int ADDR_W      = 8,
   parameter int WORD_W      = 8,
   parameter int HALF_W      = 64,
   parameter logic [HALF_W-1:0] FACTORY_ID = 64'hA5C3_0F1E_7B29_D486,
   parameter int A_BASE      = 0,
   parameter int B_BASE      = 8,
   parameter int STATUS_ADDR = 'h80,
   parameter int LOCK_BIT    = 1,
   parameter bit RD_PIPE     = 1'b1,
   localparam int NWORDS     = HALF_W / WORD_W,
   localparam int IDX_W      = $clog2(NWORDS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [2:0]        cmd_op,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [WORD_W-1:0] cmd_data,
   output logic              id_active,
   output logic              rd_valid,
   output logic [WORD_W-1:0] rd_data,
   output logic              cmd_reject
);

   generate
      if (HALF_W % WORD_W != 0) begin : g_bad_width
         $error("HALF_W must be a multiple of WORD_W");
      end
      if (NWORDS < 2) begin : g_bad_depth
         $error("each half needs at least two words");
      end
      if (LOCK_BIT < 0 || LOCK_BIT >= WORD_W) begin : g_bad_lockbit
         $error("LOCK_BIT outside the data word");
      end
      if (A_BASE + NWORDS > (1 << ADDR_W) || B_BASE + NWORDS > (1 << ADDR_W)
          || STATUS_ADDR >= (1 << ADDR_W)) begin : g_bad_map
         $error("address map does not fit ADDR_W");
      end
      if ((A_BASE < B_BASE + NWORDS) && (B_BASE < A_BASE + NWORDS)) begin : g_overlap
         $error("factory and user windows overlap");
      end
   endgenerate

   logic                    lock_q;
   logic                    wr_en, lock_set, rd_en;
   logic [IDX_W-1:0]        wr_idx;
   logic [HALF_W-1:0]       a_words, b_words;

   otp_cmd_ctrl #(
      .ADDR_W (ADDR_W),
      .NWORDS (NWORDS),
      .B_BASE (B_BASE)
   ) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .cmd_op    (cmd_op),
      .cmd_addr  (cmd_addr),
      .lock_qual (cmd_data[LOCK_BIT]),
      .locked    (lock_q),
      .id_active (id_active),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .lock_set  (lock_set),
      .rd_en     (rd_en),
      .reject    (cmd_reject)
   );

   otp_half_store #(
      .WORD_W   (WORD_W),
      .NWORDS   (NWORDS),
      .WRITABLE (1'b0),
      .INIT     (FACTORY_ID)
   ) i_half_a (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (1'b0),
      .wr_idx  ('0),
      .wr_data ('0),
      .words   (a_words)
   );

   otp_half_store #(
      .WORD_W   (WORD_W),
      .NWORDS   (NWORDS),
      .WRITABLE (1'b1),
      .INIT     ('1)
   ) i_half_b (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_data (cmd_data),
      .words   (b_words)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else if (lock_set) lock_q <= 1'b1;
   end

   otp_rd_mux #(
      .ADDR_W      (ADDR_W),
      .WORD_W      (WORD_W),
      .NWORDS      (NWORDS),
      .A_BASE      (A_BASE),
      .B_BASE      (B_BASE),
      .STATUS_ADDR (STATUS_ADDR),
      .LOCK_BIT    (LOCK_BIT),
      .RD_PIPE     (RD_PIPE)
   ) i_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (cmd_addr),
      .a_words  (a_words),
      .b_words  (b_words),
      .locked   (lock_q),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

endmodule

// File: rtl/otp_secreg_chk.sv
module otp_secreg_chk #(
   parameter bit RD_PIPE = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       cmd_valid,
   input logic [2:0] cmd_op,
   input logic       lock_qual,
   input logic       id_active,
   input logic       rd_valid,
   input logic       cmd_reject,
   input logic       b_locked
);

   // R11: the lock never falls while out of reset
   p_lock_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
      b_locked |=> b_locked);

   // R5: qualified lock request in array mode sets the lock
   p_lock_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd2 && !lock_qual && !id_active) |=> b_locked);

   // R5: nothing else raises the lock
   p_lock_only_cmd_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!b_locked && !(cmd_valid && cmd_op == 3'd2 && !lock_qual && !id_active)) |=> !b_locked);

   // R6: program while locked is refused
   p_prog_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd1 && b_locked) |=> cmd_reject);

   // R9: identification mode refuses program, lock and entry
   p_ident_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && id_active && (cmd_op == 3'd1 || cmd_op == 3'd2 || cmd_op == 3'd3))
      |=> cmd_reject);

   // R9: exit always leaves identification mode
   p_exit_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 3'd4) |=> !id_active);

   // R10: never both answer pulses
   p_one_answer_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_valid && cmd_reject));

   // R12: undefined opcodes refused
   p_bad_op_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && (cmd_op == 3'd0 || cmd_op == 3'd6 || cmd_op == 3'd7)) |=> cmd_reject);

   generate
      if (RD_PIPE) begin : g_rd_chk
         // R8: read data only follows a read taken in identification mode
         p_read_ident_r8: assert property (@(posedge clk) disable iff (!rst_n)
            rd_valid |-> $past(cmd_valid && cmd_op == 3'd5 && id_active));
      end
   endgenerate

endmodule

bind otp_secreg otp_secreg_chk #(
   .RD_PIPE (RD_PIPE)
) i_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_valid  (cmd_valid),
   .cmd_op     (cmd_op),
   .lock_qual  (cmd_data[LOCK_BIT]),
   .id_active  (id_active),
   .rd_valid   (rd_valid),
   .cmd_reject (cmd_reject),
   .b_locked   (lock_q)
);

// File: tb/test_otp_secreg.sv
module test_otp_secreg;

   localparam int CLK_PERIOD = 10;
   localparam logic [63:0] FID = 64'h1122_3344_5566_7788;
   localparam logic [2:0] OP_PR = 3'd1, OP_LK = 3'd2, OP_EN = 3'd3, OP_EX = 3'd4, OP_RD = 3'd5;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cmd_valid = 1'b0;
   logic [2:0] cmd_op = 3'd0;
   logic [7:0] cmd_addr = 8'd0;
   logic [7:0] cmd_data = 8'd0;
   logic       id_active, rd_valid, cmd_reject;
   logic [7:0] rd_data;

   int  n_cmp = 0;
   int  n_bad = 0;
   bit  done  = 1'b0;

   logic [7:0] b_exp [8];
   logic       lk_exp;

   always #(CLK_PERIOD/2) clk = ~clk;

   otp_secreg #(.FACTORY_ID(FID)) i_otp_secreg (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_valid  (cmd_valid),
      .cmd_op     (cmd_op),
      .cmd_addr   (cmd_addr),
      .cmd_data   (cmd_data),
      .id_active  (id_active),
      .rd_valid   (rd_valid),
      .rd_data    (rd_data),
      .cmd_reject (cmd_reject)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] op, input logic [7:0] addr, input logic [7:0] data,
                        output logic v, output logic [7:0] d, output logic rj);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = addr; cmd_data = data;
      @(negedge clk);
      cmd_valid = 1'b0;
      v = rd_valid; d = rd_data; rj = cmd_reject;
   endtask

   function automatic logic [7:0] model_rd(input int a);
      if (a < 8)        return FID[a*8 +: 8];
      else if (a < 16)  return b_exp[a-8];
      else if (a == 'h80) return lk_exp ? 8'hFD : 8'hFF;
      else              return 8'hFF;
   endfunction

   task automatic do_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int i = 0; i < 8; i++) b_exp[i] = 8'hFF;
      lk_exp = 1'b0;
      @(negedge clk);
   endtask

   task automatic sweep(input string req);
      logic v, rj; logic [7:0] d;
      issue(OP_EN, 8'h00, 8'h00, v, d, rj);
      check({req, " enter"}, {id_active, rj}, 2'b10);
      for (int a = 0; a < 256; a++) begin
         issue(OP_RD, 8'(a), 8'h00, v, d, rj);
         check({req, " rd_valid/reject"}, {v, rj}, 2'b10);
         check({req, " read data"}, d, model_rd(a));
      end
      issue(OP_EX, 8'h00, 8'h00, v, d, rj);
      check({req, " R9 exit"}, {id_active, rj}, 2'b00);
   endtask

   task automatic read_user(input string req);
      logic v, rj; logic [7:0] d;
      issue(OP_EN, 8'h00, 8'h00, v, d, rj);
      for (int a = 8; a < 16; a++) begin
         issue(OP_RD, 8'(a), 8'h00, v, d, rj);
         check(req, d, model_rd(a));
      end
      issue(OP_RD, 8'h80, 8'h00, v, d, rj);
      check({req, " R7 status"}, d, model_rd('h80));
      issue(OP_EX, 8'h00, 8'h00, v, d, rj);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic v, rj; logic [7:0] d;
      do_reset();
      // R1: reset state
      check("R1 reset outputs", {id_active, rd_valid, cmd_reject}, 3'b000);

      // R8: read in array mode is refused
      issue(OP_RD, 8'h03, 8'h00, v, d, rj);
      check("R8 read in array mode", {v, rj}, 2'b01);

      // R1 R2 R7 R10: full sweep after reset
      sweep("R1 R2 R7 R10 fresh");

      // R9: blocked requests in identification mode
      issue(OP_EN, 8'h00, 8'h00, v, d, rj);
      issue(OP_PR, 8'h09, 8'h00, v, d, rj);
      check("R9 prog in ident", rj, 1'b1);
      issue(OP_LK, 8'h00, 8'h00, v, d, rj);
      check("R9 lock in ident", rj, 1'b1);
      issue(OP_EN, 8'h00, 8'h00, v, d, rj);
      check("R9 enter in ident", {id_active, rj}, 2'b11);
      issue(OP_EX, 8'h00, 8'h00, v, d, rj);
      issue(OP_EX, 8'h00, 8'h00, v, d, rj);
      check("R9 exit in array mode", {id_active, rj}, 2'b00);
      read_user("R9 no effect");

      // R12: undefined opcodes in both modes
      foreach (b_exp[k]) begin end
      for (int o = 0; o < 8; o++) begin
         if (o == 0 || o == 6 || o == 7) begin
            issue(3'(o), 8'h08, 8'h00, v, d, rj);
            check("R12 bad op array", {v, rj}, 2'b01);
         end
      end
      issue(OP_EN, 8'h00, 8'h00, v, d, rj);
      issue(3'd6, 8'h08, 8'h00, v, d, rj);
      check("R12 bad op ident", {v, rj, id_active}, 3'b011);
      issue(OP_EX, 8'h00, 8'h00, v, d, rj);
      read_user("R12 no change");

      // R3: programming outside the user window
      for (int a = 0; a < 8; a++) begin
         issue(OP_PR, 8'(a), 8'h00, v, d, rj);
         check("R3 prog factory", rj, 1'b1);
      end
      issue(OP_PR, 8'h10, 8'h00, v, d, rj);
      check("R3 prog above window", rj, 1'b1);
      issue(OP_PR, 8'h80, 8'h00, v, d, rj);
      check("R3 prog status addr", rj, 1'b1);

      // R4: AND programming over several rounds
      for (int r = 0; r < 4; r++) begin
         for (int j = 0; j < 8; j++) begin
            logic [7:0] pat;
            pat = (r == 3 && j[0]) ? 8'hFF : ~(8'(1) << ((j*3 + r) % 8));
            issue(OP_PR, 8'(8 + j), pat, v, d, rj);
            check("R4 prog accepted", {v, rj}, 2'b00);
            b_exp[j] = b_exp[j] & pat;
         end
         read_user("R4 AND result");
      end

      // R5: lock request with bit 1 high has no effect
      issue(OP_LK, 8'h00, 8'h02, v, d, rj);
      check("R5 lock bit1 high accepted", rj, 1'b0);
      issue(OP_LK, 8'h00, 8'hFF, v, d, rj);
      check("R5 lock 0xFF accepted", rj, 1'b0);
      read_user("R5 still unlocked");
      issue(OP_PR, 8'h0F, 8'h7F, v, d, rj);
      check("R5 prog after unqualified lock", rj, 1'b0);
      b_exp[7] = b_exp[7] & 8'h7F;

      // R5: lock with bit 1 low, others high
      issue(OP_LK, 8'h00, 8'hFD, v, d, rj);
      check("R5 lock qualified", rj, 1'b0);
      lk_exp = 1'b1;
      sweep("R2 R5 R7 locked");

      // R6: programs refused after lock
      for (int j = 0; j < 8; j++) begin
         issue(OP_PR, 8'(8 + j), 8'h00, v, d, rj);
         check("R6 prog locked", rj, 1'b1);
      end
      read_user("R6 bytes unchanged");

      // R11: lock survives other requests
      issue(OP_LK, 8'h00, 8'hFF, v, d, rj);
      issue(OP_EN, 8'h00, 8'h00, v, d, rj);
      issue(OP_EX, 8'h00, 8'h00, v, d, rj);
      issue(3'd7, 8'h80, 8'hFF, v, d, rj);
      read_user("R11 lock sticky");

      // R1 R11: reset clears lock and erases user half
      do_reset();
      check("R1 reset after lock", {id_active, rd_valid, cmd_reject}, 3'b000);
      sweep("R1 R11 after reset");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule